// File: doc/BRIEF.md
# Cascaded CAM Match-Priority and Flag Logic

This block is the per-device flag and priority stage of a small content-addressable memory that can be stacked vertically with identical devices. A compare cycle supplies one match bit per entry and the entry valid bits. The block latches the entries that both matched and are valid, and it presents the lowest-indexed latched entry as the highest-priority match address. An advance command retires that entry so that the next responder becomes visible. Responders can therefore be read out one by one.

The cascade flags ripple from the highest-priority device towards the lowest. Each device ORs its latched local match with the match input from above, so the last device in the chain produces the system match flag. Multiple-match is raised for two or more local hits, or for a local hit while an upstream device also matched. It is combined with the upstream multiple-match by a logical OR, which stands in for the wired OR. Full is the AND of this device's local full state and the full input from above.

The match and multiple-match flags are registered only on a compare strobe, and full only on a write strobe. Output enable gates only the address bus and never the cascade flags. The block has no streaming data path, so every pin is a plain level or strobe and there is no back-pressure.

Top module: `cam_cascade_prio`

## Requirements
- R1: After reset the address-valid output is 0 and the address is 0. The local match, multiple-match and full state are cleared, so match_out equals match_in, mmatch_out equals mmatch_in and full_out is 0.
- R2: In the cycle after a compare strobe with oe=1, addr_vld is 1 and hp_addr is the lowest index i with match_vec[i]=1 and valid_vec[i]=1. If no such index exists, addr_vld is 0.
- R3: An advance strobe without a compare strobe clears the current highest-priority entry. In the next cycle hp_addr is the next higher index among the latched entries, or addr_vld is 0 if none remain. An advance with no latched entries has no effect.
- R4: match_out = (a latched local match exists) OR match_in, where the local match is captured at the last compare.
- R5: mmatch_out = mmatch_in OR (at least two local hits at the last compare) OR (at least one local hit AND match_in).
- R6: The local match and multiple-match state change only in the cycle after a compare strobe. Advance strobes and match_vec changes without a compare strobe leave match_out and mmatch_out unchanged.
- R7: A write strobe captures local full as the AND of all valid_vec bits. full_out = local full AND full_in. Without a write strobe, valid_vec changes do not alter full_out.
- R8: With oe=0, addr_vld and hp_addr are 0. The cascade flags do not depend on oe.
- R9: sts_drive is 1 when this device has a latched local match and match_in=0. It is also 1 when chain_last=1 and match_out=0. Otherwise it is 0.
- R10: When a compare strobe and an advance strobe occur in the same cycle, the compare wins and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_strobe | input | 1 | Compare cycle completes; latch hits and flags |
| wr_strobe | input | 1 | Write cycle completes; latch local full |
| adv_strobe | input | 1 | Retire current highest-priority responder |
| oe | input | 1 | Output enable for the address bus |
| chain_last | input | 1 | Tie high on the lowest-priority device |
| match_vec | input | ENTRIES | Per-entry compare result |
| valid_vec | input | ENTRIES | Per-entry valid bit |
| match_in | input | 1 | Match flag from the higher-priority device |
| mmatch_in | input | 1 | Multiple-match from the higher-priority device |
| full_in | input | 1 | Full flag from the higher-priority device (tie high on the first device) |
| hp_addr | output | IDX_W | Highest-priority match address |
| addr_vld | output | 1 | hp_addr is valid and enabled |
| match_out | output | 1 | Cascaded match flag |
| mmatch_out | output | 1 | Cascaded multiple-match flag |
| full_out | output | 1 | Cascaded full flag |
| sts_drive | output | 1 | This device drives the status word |

## Verification
A corrupted responder latch shows at the ports within one cycle. It appears as a wrong hp_addr after the compare, or as an address that fails to move up or that repeats after an advance. A wrong local match or multiple-match register shows on match_out, mmatch_out and sts_drive in the cycle after the compare and persists until the next compare. It also shows as a flag that changes on an advance. A wrong full register shows on full_out one cycle after a write strobe, or as a change on full_out when there was no write strobe.

// File: rtl/cam_prio_pkg.sv
package cam_prio_pkg;
  typedef enum logic [1:0] {
    LCMD_HOLD = 2'd0,
    LCMD_LOAD = 2'd1,
    LCMD_RETIRE = 2'd2
  } latch_cmd_e;

  function automatic latch_cmd_e pick_cmd(input logic cmp, input logic adv);
    if (cmp) return LCMD_LOAD;
    else if (adv) return LCMD_RETIRE;
    else return LCMD_HOLD;
  endfunction
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          found,
  output logic [N-1:0]  first_oh
);
  always_comb begin
    idx = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign first_oh = req & (~req + N'(1));
endmodule

// File: rtl/cam_resp_latch.sv
module cam_resp_latch
  import cam_prio_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp,
  input  logic         adv,
  input  logic [N-1:0] hits,
  input  logic [N-1:0] first_oh,
  output logic [N-1:0] pend
);
  latch_cmd_e cmd;
  assign cmd = pick_cmd(cmp, adv);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      unique case (cmd)
        LCMD_LOAD:   pend <= hits;
        LCMD_RETIRE: pend <= pend & ~first_oh;
        default:     pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/cam_flag_cascade.sv
module cam_flag_cascade #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp,
  input  logic         wr,
  input  logic [N-1:0] hits,
  input  logic [N-1:0] valid_vec,
  input  logic         match_in,
  input  logic         mmatch_in,
  input  logic         full_in,
  input  logic         chain_last,
  output logic         match_out,
  output logic         mmatch_out,
  output logic         full_out,
  output logic         sts_drive
);
  logic loc_hit_q, loc_multi_q, loc_full_q;
  logic multi_now;

  assign multi_now = |(hits & (hits - N'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_hit_q   <= 1'b0;
      loc_multi_q <= 1'b0;
      loc_full_q  <= 1'b0;
    end else begin
      if (cmp) begin
        loc_hit_q   <= |hits;
        loc_multi_q <= multi_now;
      end
      if (wr) loc_full_q <= &valid_vec;
    end
  end

  assign match_out  = loc_hit_q | match_in;
  assign mmatch_out = mmatch_in | loc_multi_q | (loc_hit_q & match_in);
  assign full_out   = loc_full_q & full_in;
  assign sts_drive  = (loc_hit_q & ~match_in) | (chain_last & ~match_out);
endmodule

// File: rtl/cam_cascade_prio.sv
module cam_cascade_prio #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_strobe,
  input  logic               wr_strobe,
  input  logic               adv_strobe,
  input  logic               oe,
  input  logic               chain_last,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               match_in,
  input  logic               mmatch_in,
  input  logic               full_in,
  output logic [IDX_W-1:0]   hp_addr,
  output logic               addr_vld,
  output logic               match_out,
  output logic               mmatch_out,
  output logic               full_out,
  output logic               sts_drive
);
  logic [ENTRIES-1:0] hits, pend, first_oh;
  logic [IDX_W-1:0]   enc_idx;
  logic               enc_found;

  assign hits = match_vec & valid_vec;

  cam_prio_enc #(.N(ENTRIES)) u_enc (
    .req(pend), .idx(enc_idx), .found(enc_found), .first_oh(first_oh)
  );

  cam_resp_latch #(.N(ENTRIES)) u_latch (
    .clk(clk), .rst_n(rst_n), .cmp(cmp_strobe), .adv(adv_strobe),
    .hits(hits), .first_oh(first_oh), .pend(pend)
  );

  cam_flag_cascade #(.N(ENTRIES)) u_flags (
    .clk(clk), .rst_n(rst_n), .cmp(cmp_strobe), .wr(wr_strobe),
    .hits(hits), .valid_vec(valid_vec), .match_in(match_in),
    .mmatch_in(mmatch_in), .full_in(full_in), .chain_last(chain_last),
    .match_out(match_out), .mmatch_out(mmatch_out), .full_out(full_out),
    .sts_drive(sts_drive)
  );

  assign addr_vld = oe & enc_found;
  assign hp_addr  = addr_vld ? enc_idx : '0;
endmodule

// File: rtl/cam_cascade_prio_chk.sv
module cam_cascade_prio_chk #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_strobe,
  input logic             wr_strobe,
  input logic             adv_strobe,
  input logic             oe,
  input logic             match_in,
  input logic             mmatch_in,
  input logic             full_in,
  input logic [IDX_W-1:0] hp_addr,
  input logic             addr_vld,
  input logic             match_out,
  input logic             mmatch_out,
  input logic             full_out,
  input logic             sts_drive
);
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cmp_strobe) && $stable(match_in) && $stable(mmatch_in))
      |-> ($stable(match_out) && $stable(mmatch_out)));

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_strobe) && $stable(full_in)) |-> $stable(full_out));

  assert_multi_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mmatch_out && !mmatch_in) |-> match_out);

  assert_addr_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!addr_vld && hp_addr == '0));

  assert_adv_moves_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adv_strobe) && !$past(cmp_strobe) && $past(addr_vld) && oe)
      |-> (!addr_vld || hp_addr > $past(hp_addr)));

  assert_sts_yield_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_in |-> !sts_drive);
endmodule

bind cam_cascade_prio cam_cascade_prio_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .wr_strobe(wr_strobe),
  .adv_strobe(adv_strobe), .oe(oe), .match_in(match_in), .mmatch_in(mmatch_in),
  .full_in(full_in), .hp_addr(hp_addr), .addr_vld(addr_vld),
  .match_out(match_out), .mmatch_out(mmatch_out), .full_out(full_out),
  .sts_drive(sts_drive)
);

// File: tb/cam_cascade_prio_tb.sv
`timescale 1ns/1ps
module cam_cascade_prio_tb;
  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n, cmp_strobe, wr_strobe, adv_strobe, oe, chain_last;
  logic [N-1:0] match_vec, valid_vec;
  logic match_in, mmatch_in, full_in;
  logic [IW-1:0] hp_addr;
  logic addr_vld, match_out, mmatch_out, full_out, sts_drive;

  int checks = 0, failures = 0;
  logic [N-1:0] m_pend;
  logic m_hit, m_multi, m_full;

  always #2.5 clk = ~clk;

  cam_cascade_prio #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_strobe(cmp_strobe), .wr_strobe(wr_strobe),
    .adv_strobe(adv_strobe), .oe(oe), .chain_last(chain_last),
    .match_vec(match_vec), .valid_vec(valid_vec), .match_in(match_in),
    .mmatch_in(mmatch_in), .full_in(full_in), .hp_addr(hp_addr),
    .addr_vld(addr_vld), .match_out(match_out), .mmatch_out(mmatch_out),
    .full_out(full_out), .sts_drive(sts_drive)
  );

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    int lo;
    logic e_match, e_mm, e_sts;
    lo = lowest(m_pend);
    e_match = m_hit | match_in;
    e_mm = mmatch_in | m_multi | (m_hit & match_in);
    e_sts = (m_hit & ~match_in) | (chain_last & ~e_match);
    chk(req, "addr_vld", int'(addr_vld), (oe && lo >= 0) ? 1 : 0);
    chk(req, "hp_addr", int'(hp_addr), (oe && lo >= 0) ? lo : 0);
    chk({req, "/R4"}, "match_out", int'(match_out), int'(e_match));
    chk({req, "/R5"}, "mmatch_out", int'(mmatch_out), int'(e_mm));
    chk({req, "/R7"}, "full_out", int'(full_out), int'(m_full & full_in));
    chk({req, "/R9"}, "sts_drive", int'(sts_drive), int'(e_sts));
  endtask

  // Inputs are set before the call (at negedge); one clock passes, the model updates.
  task automatic step(input string req);
    logic [N-1:0] h;
    @(posedge clk);
    h = match_vec & valid_vec;
    if (!rst_n) begin
      m_pend = '0; m_hit = 0; m_multi = 0; m_full = 0;
    end else begin
      if (cmp_strobe) begin
        m_pend = h; m_hit = (h != 0); m_multi = (ones(h) >= 2);
      end else if (adv_strobe && lowest(m_pend) >= 0) begin
        m_pend[lowest(m_pend)] = 1'b0;
      end
      if (wr_strobe) m_full = &valid_vec;
    end
    #1;
    @(negedge clk);
    cmp_strobe = 0; wr_strobe = 0; adv_strobe = 0;
    #0.5;
    check_all(req);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cmp_strobe = 0; wr_strobe = 0; adv_strobe = 0; oe = 1;
    chain_last = 0; match_vec = '0; valid_vec = '0;
    match_in = 0; mmatch_in = 0; full_in = 1;
    m_pend = '0; m_hit = 0; m_multi = 0; m_full = 0;
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    step("R1");
    match_in = 1; mmatch_in = 1; #0.5; check_all("R1");
    match_in = 0; mmatch_in = 0;

    // R2 compare with invalid low entries masked
    match_vec = 16'b1010_0000_0010_0101; valid_vec = 16'b1111_1111_1111_1010;
    cmp_strobe = 1; step("R2");
    // R6 match_vec changes without compare
    match_vec = '0; step("R6");
    // R3 step through responders
    adv_strobe = 1; step("R3");
    adv_strobe = 1; step("R3");
    adv_strobe = 1; step("R3");
    chk("R3", "exhausted addr_vld", int'(addr_vld), 0);
    chk("R6", "match_out held after advances", int'(match_out), 1);
    adv_strobe = 1; step("R3");
    // R8 oe gating, flags still visible
    match_vec = 16'h0300; valid_vec = 16'hFFFF; cmp_strobe = 1; step("R2");
    oe = 0; #0.5; check_all("R8"); oe = 1;
    // R10 compare beats advance
    match_vec = 16'h0041; cmp_strobe = 1; adv_strobe = 1; step("R10");
    chk("R10", "hp_addr", int'(hp_addr), 0);
    // R5 single local hit with upstream match
    match_vec = 16'h0800; cmp_strobe = 1; step("R5");
    match_in = 1; #0.5; check_all("R5"); match_in = 0;
    // R7 full
    valid_vec = 16'hFFFF; wr_strobe = 1; step("R7");
    valid_vec = 16'h7FFF; step("R7");
    full_in = 0; #0.5; check_all("R7"); full_in = 1;
    wr_strobe = 1; step("R7");
    // R9 lowest device with no system match
    chain_last = 1; match_vec = '0; cmp_strobe = 1; step("R9");

    for (int k = 0; k < 600; k++) begin
      match_vec  = N'($urandom);
      valid_vec  = ($urandom_range(0, 5) == 0) ? '1 : N'($urandom);
      cmp_strobe = ($urandom_range(0, 3) == 0);
      adv_strobe = ($urandom_range(0, 1) == 0);
      wr_strobe  = ($urandom_range(0, 3) == 0);
      oe         = ($urandom_range(0, 4) != 0);
      chain_last = $urandom_range(0, 1);
      match_in   = ($urandom_range(0, 2) == 0);
      mmatch_in  = ($urandom_range(0, 4) == 0);
      full_in    = ($urandom_range(0, 3) != 0);
      step("R2/R3/R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule